// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Each word is 36 bits wide and is split into four 9-bit byte lanes. A command presented on one rising clock edge has its data phase in the following cycle, for reads and for writes alike. Because of this, reads and writes can follow each other on every cycle with no idle turnaround cycles.

Write data is registered from the bidirectional bus at the edge that closes the data phase. Read data is not registered: it flows combinationally from the array to the bus during the cycle after the read was loaded.

A load cycle starts a new access. An advance cycle steps a 2-bit burst counter inside a 4-word block, in linear or interleaved order. The block also has a clock-enable stall, a one-cycle deselect, an asynchronous output enable and a sleep input that preserves the array.

The control is a four-state machine:
- **IDLE**: no access is in progress.
- **READ**: a read data phase is in progress.
- **WRITE**: a write data phase is in progress.
- **SLEEP**: the sleep input is high.

Its transitions are named as follows:
- **load_read**: from any state except SLEEP-held, a selected load with the read/write select high goes to READ.
- **load_write**: a selected load with the read/write select low goes to WRITE.
- **advance**: READ or WRITE stays in the same state and the burst beat steps by one.
- **deselect**: a load with the chip not selected goes to IDLE.
- **stall**: with the clock enable high, the state is held.
- **enter_sleep**: any state goes to SLEEP while the sleep input is high.
- **wake**: from SLEEP, the next enabled edge acts exactly as it would from IDLE.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset the machine is IDLE and the data bus is not driven.
- R2: A load (adv_ld low) selects the chip only when ce0_n is low, ce1 is high and ce2_n is low. With any one of these inactive, the load acts as a deselect.
- R3: A selected load with rd_wr_n low is a write. The data present on dq during the next cycle is stored at the edge that ends that cycle. Only the lanes whose bwe_n bit is 0 are written; lane i occupies dq bits 9*i+8 down to 9*i.
- R4: A selected load with rd_wr_n high is a read. During the cycle right after the loading edge, dq shows the addressed word with no added latency (provided oe_n is low).
- R5: Reads and writes may be loaded on consecutive edges in any mix without idle cycles. A read loaded right after a write returns the newly written data.
- R6: On an advance edge (adv_ld high) with a burst active, addr, rd_wr_n and the chip enables are ignored. The access continues with the same direction, and address bits above bit 1 stay fixed.
- R7: With burst_il low, beat k of a burst addresses low bits (start + k) mod 4, so the burst wraps inside its 4-word block.
- R8: With burst_il high, beat k addresses low bits start XOR (k mod 4).
- R9: bwe_n is sampled again on every advance edge and governs the lanes written for that beat.
- R10: After a deselect edge the bus is released in the next cycle. Advance edges that occur while no burst is active leave the machine IDLE.
- R11: An edge with cke_n high changes no state and writes nothing. Read data on the bus holds, and a pending write waits for the next enabled edge.
- R12: While oe_n is high the bus is released at once, without waiting for a clock edge, whatever the access state.
- R13: An edge with sleep high enters SLEEP: the bus is released, any pending write is dropped and the array is kept. The first enabled edge after sleep goes low acts as from a deselected state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state (array untouched) |
| cke_n | input | 1 | Active-low clock enable; high stalls the block |
| sleep | input | 1 | High enters the sleep state |
| adv_ld | input | 1 | Low loads a new command, high advances the burst |
| rd_wr_n | input | 1 | High for read, low for write (used on load edges) |
| ce0_n | input | 1 | Active-low chip enable |
| ce1 | input | 1 | Active-high chip enable |
| ce2_n | input | 1 | Active-low chip enable |
| burst_il | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| bwe_n | input | 4 | Active-low lane write enables |
| addr | input | AW | Word address |
| dq | inout | 36 | Bidirectional data bus |

## Verification
A wrong control state shows on dq in the data-phase cycle that directly follows the faulty edge. If the machine is wrongly left in READ, dq stays driven when it should have been released. If a write is lost or a wrong lane mask is applied, the error appears when that word is next read, which is one cycle after the read load. A burst counter that steps wrongly puts the wrong word on the bus on the very next beat. The reference model in the bench predicts dq for every cycle, so a single wrong edge is reported in the cycle where it first becomes visible.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } zbt_state_e;

    localparam int BURST_BITS = 2;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] beat,
    input  logic          il,
    output logic [CW-1:0] low
);
    logic [CW-1:0] lin_low;
    logic [CW-1:0] xor_low;

    assign lin_low = start + beat;
    assign xor_low = start ^ beat;

    always_comb begin
        if (il) low = xor_low;
        else    low = lin_low;
    end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !lane_wr_n[g]) begin
                lane_mem[addr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = lane_mem[addr];
    end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             sleep,
    input  logic             adv_ld,
    input  logic             rd_sel,
    input  logic             chip_on,
    input  logic             il,
    input  logic [LANES-1:0] bwe_n,
    input  logic [AW-1:0]    addr,
    output zbt_state_e       st,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] lane_wr_n,
    output logic             wr_en,
    output logic             rd_act
);
    localparam int BW = BURST_BITS;

    zbt_state_e       st_q, st_d;
    logic [AW-1:0]    base_q, base_d;
    logic [BW-1:0]    beat_q, beat_d;
    logic [LANES-1:0] be_q, be_d;
    logic [BW-1:0]    low;
    logic             step;

    assign step = ~cke_n & ~sleep;

    zbt_burst_seq #(.CW(BW)) u_seq (
        .start (base_q[BW-1:0]),
        .beat  (beat_q),
        .il    (il),
        .low   (low)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            beat_q <= '0;
            be_q   <= '1;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            beat_q <= beat_d;
            be_q   <= be_d;
        end
    end

    // next-state: load_read, load_write, advance, deselect, stall, enter_sleep, wake
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        beat_d = beat_q;
        be_d   = be_q;
        if (sleep) begin
            st_d = ST_SLEEP;
        end else if (!cke_n) begin
            unique case (st_q)
                ST_IDLE, ST_SLEEP: begin
                    if (!adv_ld && chip_on) begin
                        st_d   = rd_sel ? ST_READ : ST_WRITE;
                        base_d = addr;
                        beat_d = '0;
                        be_d   = bwe_n;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_READ, ST_WRITE: begin
                    if (!adv_ld) begin
                        if (chip_on) begin
                            st_d   = rd_sel ? ST_READ : ST_WRITE;
                            base_d = addr;
                            beat_d = '0;
                            be_d   = bwe_n;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end else begin
                        beat_d = beat_q + 1'b1;
                        be_d   = bwe_n;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        st        = st_q;
        cur_addr  = {base_q[AW-1:BW], low};
        lane_wr_n = be_q;
        wr_en     = (st_q == ST_WRITE) && step;
        rd_act    = (st_q == ST_READ);
    end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
    import zbt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cke_n,
    input  logic                sleep,
    input  logic                adv_ld,
    input  logic                rd_wr_n,
    input  logic                ce0_n,
    input  logic                ce1,
    input  logic                ce2_n,
    input  logic                burst_il,
    input  logic                oe_n,
    input  logic [LANES-1:0]    bwe_n,
    input  logic [AW-1:0]       addr,
    inout  wire  [LANES*LW-1:0] dq
);
    localparam int DW = LANES * LW;

    zbt_state_e       st;
    logic [AW-1:0]    cur_addr;
    logic [LANES-1:0] lane_wr_n;
    logic             wr_en;
    logic             rd_act;
    logic             chip_on;
    logic [DW-1:0]    rd_data;
    logic             drive;

    assign chip_on = ~ce0_n & ce1 & ~ce2_n;

    zbt_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .sleep     (sleep),
        .adv_ld    (adv_ld),
        .rd_sel    (rd_wr_n),
        .chip_on   (chip_on),
        .il        (burst_il),
        .bwe_n     (bwe_n),
        .addr      (addr),
        .st        (st),
        .cur_addr  (cur_addr),
        .lane_wr_n (lane_wr_n),
        .wr_en     (wr_en),
        .rd_act    (rd_act)
    );

    zbt_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk       (clk),
        .we        (wr_en),
        .lane_wr_n (lane_wr_n),
        .addr      (cur_addr),
        .wdata     (dq),
        .rdata     (rd_data)
    );

    assign drive = rd_act & ~oe_n;
    assign dq    = drive ? rd_data : {DW{1'bz}};
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk
    import zbt_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          sleep,
    input logic          adv_ld,
    input logic          rd_wr_n,
    input logic          ce0_n,
    input logic          ce1,
    input logic          ce2_n,
    input zbt_state_e    st,
    input logic [AW-1:0] cur_addr
);
    logic sel_ok;
    logic live;
    logic bursting;

    assign sel_ok   = !ce0_n && ce1 && !ce2_n;
    assign live     = !cke_n && !sleep;
    assign bursting = (st == ST_READ) || (st == ST_WRITE);

    // R5: a selected load starts the commanded direction on the next cycle
    a_r5_load_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && sel_ok) |=> (st == ($past(rd_wr_n) ? ST_READ : ST_WRITE)));

    // R10: a load without chip select ends in IDLE
    a_r10_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && !sel_ok) |=> (st == ST_IDLE));

    // R11: a stalled edge keeps state and address
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n && !sleep) |=> ($stable(st) && $stable(cur_addr)));

    // R13: sleep always lands in SLEEP
    a_r13_sleep_enter: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st == ST_SLEEP));

    // R6: an advance keeps direction and the 4-word block
    a_r6_adv_keeps_block: assert property (@(posedge clk) disable iff (!rst_n)
        (live && adv_ld && bursting) |=>
            ((st == $past(st)) && (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]))));
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .sleep    (sleep),
    .adv_ld   (adv_ld),
    .rd_wr_n  (rd_wr_n),
    .ce0_n    (ce0_n),
    .ce1      (ce1),
    .ce2_n    (ce2_n),
    .st       (st),
    .cur_addr (cur_addr)
);

// File: tb/sim_zbt_ft_sram.sv
module sim_zbt_ft_sram;
    localparam int AW = 8;
    localparam int LANES = 4;
    localparam int LW = 9;
    localparam int DW = LANES * LW;
    localparam logic [2:0] CS_ON = 3'b010;
    localparam logic [DW-1:0] REL = {DW{1'b1}};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cke_n, sleep, adv_ld, rd_wr_n, ce0_n, ce1, ce2_n, burst_il, oe_n;
    logic [LANES-1:0] bwe_n;
    logic [AW-1:0] addr;
    wire  [DW-1:0] dq;
    logic tb_drv;
    logic [DW-1:0] tb_val;

    assign dq = tb_drv ? tb_val : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup pu (dq[i]);
    end

    zbt_ft_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep), .adv_ld(adv_ld),
        .rd_wr_n(rd_wr_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .burst_il(burst_il), .oe_n(oe_n), .bwe_n(bwe_n), .addr(addr), .dq(dq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: 0 idle, 1 read, 2 write, 3 sleep
    int m_state;
    logic [AW-1:0] m_base, m_addr;
    int m_beat;
    logic [LANES-1:0] m_be;
    logic [DW-1:0] m_mem [0:(1<<AW)-1];

    function automatic logic [DW-1:0] exp_now();
        if (m_state == 1 && !oe_n) return m_mem[m_addr];
        return REL;
    endfunction

    task automatic report(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int low;
        logic [DW-1:0] w;
        if (sleep) begin
            m_state = 3;
        end else if (!cke_n) begin
            if (m_state == 2) begin
                w = m_mem[m_addr];
                for (int l = 0; l < LANES; l++)
                    if (!m_be[l]) w[l*LW +: LW] = tb_val[l*LW +: LW];
                m_mem[m_addr] = w;
            end
            if (!adv_ld) begin
                if (!ce0_n && ce1 && !ce2_n) begin
                    m_state = rd_wr_n ? 1 : 2;
                    m_base = addr; m_addr = addr; m_beat = 0; m_be = bwe_n;
                end else begin
                    m_state = 0;
                end
            end else if (m_state == 1 || m_state == 2) begin
                m_beat = (m_beat + 1) % 4;
                if (burst_il) low = int'(m_base[1:0]) ^ m_beat;
                else          low = (int'(m_base[1:0]) + m_beat) % 4;
                m_addr = {m_base[AW-1:2], 2'(low)};
                m_be = bwe_n;
            end else begin
                m_state = 0;
            end
        end
    endtask

    task automatic cyc(input string tag, input logic adv, input logic rw, input logic [AW-1:0] a,
                       input logic [LANES-1:0] be, input logic [2:0] cs, input logic ckn,
                       input logic slp, input logic [DW-1:0] wd);
        adv_ld = adv; rd_wr_n = rw; addr = a; bwe_n = be;
        {ce0_n, ce1, ce2_n} = cs; cke_n = ckn; sleep = slp;
        tb_val = wd; tb_drv = (m_state == 2);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        tb_drv = (m_state == 2);
        #1;
        if (!tb_drv) report(tag, dq, exp_now());
    endtask

    task automatic lit(input string tag, input logic [DW-1:0] exp);
        report(tag, dq, exp);
    endtask

    localparam logic [DW-1:0] WA = 36'h1_3579_BDF0, WB = 36'h9_8765_4321, WC = 36'h1_2345_6789;
    localparam logic [DW-1:0] WD = 36'h4_4444_0001, WE = 36'h0_F0F0_F0F0;
    localparam logic [DW-1:0] W0 = 36'h0_0000_AAA1, W1 = 36'h0_0000_BBB2;
    localparam logic [DW-1:0] W2 = 36'h0_0000_CCC3, W3 = 36'h0_0000_0DD4;
    localparam logic [DW-1:0] I0 = 36'h2_1000_0000, I1 = 36'h2_2000_0000;
    localparam logic [DW-1:0] I2 = 36'h2_3000_0000, I3 = 36'h2_4000_0000;
    localparam logic [DW-1:0] JNK = 36'h5_5555_5555, RV = 36'h3_0303_0303;
    localparam logic [DW-1:0] M02 = 36'h0_07FC_01FF;

    initial begin
        rst_n = 0; cke_n = 0; sleep = 0; adv_ld = 1; rd_wr_n = 1;
        {ce0_n, ce1, ce2_n} = CS_ON; burst_il = 0; oe_n = 0; bwe_n = '1; addr = '0;
        tb_drv = 0; tb_val = '0; m_state = 0; m_base = '0; m_addr = '0; m_beat = 0; m_be = '1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1 lit("R1", REL);

        // R3 write with lane mask; R4 flow-through read; R5 mixing
        cyc("R3", 0, 0, 8'h11, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R3", 0, 0, 8'h11, 4'b1010, CS_ON, 0, 0, WC);
        cyc("R3", 0, 0, 8'h10, 4'b0000, CS_ON, 0, 0, WB);
        cyc("R4", 0, 1, 8'h11, 4'b0000, CS_ON, 0, 0, WA);
        lit("R3", (WB & M02) | (WC & ~M02));
        cyc("R5", 0, 0, 8'h12, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R5", 0, 1, 8'h10, 4'b0000, CS_ON, 0, 0, WD);
        lit("R5", WA);
        cyc("R5", 0, 1, 8'h12, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R5", WD);

        // R2 select decode, R10 deselect
        cyc("R10", 0, 1, 8'h10, 4'b0000, 3'b110, 0, 0, JNK);
        lit("R10", REL);
        cyc("R2", 0, 1, 8'h10, 4'b0000, 3'b000, 0, 0, JNK);
        lit("R2", REL);
        cyc("R2", 0, 1, 8'h10, 4'b0000, 3'b011, 0, 0, JNK);
        lit("R2", REL);
        cyc("R10", 1, 1, 8'h10, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R10", REL);

        // linear burst write with per-beat lane enables (R7, R9)
        cyc("R3", 0, 0, 8'h21, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R7", 0, 0, 8'h22, 4'b0000, CS_ON, 0, 0, WE);
        cyc("R7", 1, 1, 8'hFF, 4'b0000, 3'b111, 0, 0, W0);
        cyc("R7", 1, 1, 8'h00, 4'b0000, 3'b111, 0, 0, W1);
        cyc("R9", 1, 0, 8'h00, 4'b1110, CS_ON, 0, 0, W2);
        cyc("R9", 0, 1, 8'h00, 4'b0000, 3'b111, 0, 0, W3);

        // linear burst read with ignored inputs on advance (R6), stall (R11), wrap (R7)
        cyc("R7", 0, 1, 8'h22, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R7", W0);
        cyc("R6", 1, 0, 8'hFF, 4'b0000, 3'b101, 0, 0, JNK);
        lit("R6", W1);
        cyc("R11", 0, 0, 8'h40, 4'b0000, CS_ON, 1, 0, JNK);
        lit("R11", W1);
        cyc("R11", 1, 1, 8'h40, 4'b0000, CS_ON, 1, 0, JNK);
        lit("R11", W1);
        cyc("R7", 1, 0, 8'hC3, 4'b0000, 3'b111, 0, 0, JNK);
        lit("R7", W2);
        cyc("R9", 1, 1, 8'h00, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R9", (WE & ~36'h1FF) | (W3 & 36'h1FF));
        cyc("R7", 1, 1, 8'h00, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R7", W0);

        // stall inside a write data phase (R11)
        cyc("R11", 0, 0, 8'h30, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R11", 0, 1, 8'h31, 4'b0000, CS_ON, 1, 0, JNK);
        cyc("R11", 0, 1, 8'h30, 4'b0000, CS_ON, 0, 0, RV);
        lit("R11", RV);

        // interleaved order (R8)
        cyc("R10", 0, 1, 8'h00, 4'b0000, 3'b111, 0, 0, JNK);
        burst_il = 1;
        cyc("R8", 0, 0, 8'h31, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, I0);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, I1);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, I2);
        cyc("R8", 0, 1, 8'h32, 4'b0000, CS_ON, 0, 0, I3);
        lit("R8", I3);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R8", I2);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R8", I1);
        cyc("R8", 1, 0, 8'h00, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R8", I0);
        cyc("R10", 0, 1, 8'h00, 4'b0000, 3'b111, 0, 0, JNK);
        burst_il = 0;

        // asynchronous output enable (R12)
        cyc("R12", 0, 1, 8'h10, 4'b0000, CS_ON, 0, 0, JNK);
        oe_n = 1;
        #1 lit("R12", REL);
        oe_n = 0;
        #1 lit("R12", WA);

        // sleep drops pending write and keeps array (R13)
        cyc("R13", 0, 0, 8'h10, 4'b0000, CS_ON, 0, 0, JNK);
        cyc("R13", 0, 0, 8'h10, 4'b0000, CS_ON, 0, 1, JNK);
        lit("R13", REL);
        cyc("R13", 1, 1, 8'h10, 4'b0000, CS_ON, 0, 1, JNK);
        cyc("R13", 1, 1, 8'h10, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R13", REL);
        cyc("R13", 0, 1, 8'h10, 4'b0000, CS_ON, 0, 0, JNK);
        lit("R13", WA);
        cyc("R10", 0, 1, 8'h00, 4'b0000, 3'b111, 0, 0, JNK);
        lit("R10", REL);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule